// File: doc/BRIEF.md
# GPIO Edge-Event Interrupt Unit

This block sits behind a 32-pin general-purpose port and turns selected transitions on the pins into interrupt requests. Every clock it compares each pin with the value that pin had on the previous clock. A transition of the configured kind sets a sticky event bit. Software clears event bits by writing ones to them. A mask register decides which event bits reach the single combined interrupt output. The pins are expected to arrive already synchronized to the clock.

Software reaches the event, mask and sense-control registers through a simple register port. Writes take effect on the next clock edge. Reads are combinational on the address. The parameter `SENSE_WIDE` selects one of two sense formats. The compact format gives each pin one bit in a single register and chooses between falling-only and both-edge detection. The wide format gives each pin a 2-bit code, split over two registers, and adds rising-only detection.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset the event, mask and both sense registers read 0 and `irq_o` is low.
- R2: Register offsets are 0x0C event, 0x10 mask, 0x14 sense A and 0x18 sense B. Pin n owns bit (31 - n) of the event and mask registers.
- R3: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged, so writing all ones clears every pending event.
- R4: If an edge on a pin and a clearing write to that pin's event bit land on the same clock, the event bit stays set.
- R5: `irq_o` is high exactly when at least one bit is set in both the event and mask registers. A mask bit of 1 enables its pin.
- R6: Event bits latch whatever the mask value is. The mask only gates `irq_o`.
- R7: Compact format (`SENSE_WIDE`=0): sense A bit (31 - n) set to 1 makes pin n detect falling edges only, and 0 makes it detect both edges.
- R8: Wide format (`SENSE_WIDE`=1): pins 0 to 15 use sense A and pins 16 to 31 use sense B. Each pin's field is bits [(15 - n mod 16)*2 +: 2]. Code 2'b10 detects falling edges, 2'b01 rising edges, and both 2'b00 and 2'b11 detect both edges.
- R9: In the compact format, sense B reads 0 and writes to it have no effect.
- R10: An edge is a difference between a pin and its value on the previous clock. No event is raised on the first clock after reset, whatever the pin levels are.
- R11: A qualifying edge present before a rising clock edge is visible in the event register and on `irq_o` directly after that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Synchronized pin levels, bit n is pin n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | NPINS | Write data |
| rdata_o | output | NPINS | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The in-RTL assertions check on every cycle that pending events persist until they are cleared, that every detected edge ends up in the event register even when a clear collides with it, that an edge only appears on a pin that actually changed, and that the interrupt never rises without a new edge or a mask write behind it. Only the bench scenarios can show that the sense codes pick the right edge direction for every pin and bit position in both formats, that the compact instance ignores sense B, that reset does not produce events, and that partial clears and mask patterns give the right interrupt level.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int OFS_EVT   = 'h0C;
  localparam int OFS_MASK  = 'h10;
  localparam int OFS_SNS_A = 'h14;
  localparam int OFS_SNS_B = 'h18;

  typedef enum logic [1:0] {
    SNS_BOTH     = 2'b00,
    SNS_RISE     = 2'b01,
    SNS_FALL     = 2'b10,
    SNS_BOTH_ALT = 2'b11
  } sns_code_e;
endpackage

// File: rtl/gpio_sense_cfg.sv
module gpio_sense_cfg
  import gpio_evt_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter int ADDR_W     = 8,
  parameter bit SENSE_WIDE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  sns_a_o,
  output logic [NPINS-1:0]  sns_b_o,
  output logic [NPINS-1:0]  rise_en_o,
  output logic [NPINS-1:0]  fall_en_o
);
  localparam int PER_REG = NPINS / 2;

  logic [NPINS-1:0] sns_a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           sns_a_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(OFS_SNS_A))      sns_a_q <= wdata_i;
  end
  assign sns_a_o = sns_a_q;

  if (SENSE_WIDE) begin : g_wide
    logic [NPINS-1:0] sns_b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         sns_b_q <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(OFS_SNS_B))    sns_b_q <= wdata_i;
    end
    assign sns_b_o = sns_b_q;

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
      localparam int SH = (PER_REG - 1 - (n % PER_REG)) * 2;
      sns_code_e code;
      if (n < PER_REG) begin : g_lo
        assign code = sns_code_e'(sns_a_q[SH +: 2]);
      end else begin : g_hi
        assign code = sns_code_e'(sns_b_q[SH +: 2]);
      end
      assign rise_en_o[n] = (code != SNS_FALL);
      assign fall_en_o[n] = (code != SNS_RISE);
    end
  end else begin : g_compact
    assign sns_b_o = '0;
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
      assign rise_en_o[n] = ~sns_a_q[NPINS-1-n];
      assign fall_en_o[n] = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] rise_en_i,
  input  logic [NPINS-1:0] fall_en_i,
  output logic [NPINS-1:0] edge_o
);
  logic [NPINS-1:0] prev_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      vld_q  <= 1'b1;
    end
  end

  // prev_q is meaningless until one sample has been taken
  assign edge_o = vld_q ? (( pin_i & ~prev_q & rise_en_i) |
                           (~pin_i &  prev_q & fall_en_i)) : '0;

  assert_edge_on_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o != '0) |-> ((edge_o & ~(pin_i ^ $past(pin_i))) == '0));
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] edge_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic             mask_wr_i,
  input  logic [NPINS-1:0] mask_wdata_i,
  output logic [NPINS-1:0] evt_o,
  output logic [NPINS-1:0] mask_o,
  output logic             irq_o
);
  logic [NPINS-1:0] evt_set, ev_q, mask_q;

  // pin n lands on register bit NPINS-1-n
  for (genvar n = 0; n < NPINS; n++) begin : g_map
    assign evt_set[NPINS-1-n] = edge_i[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      ev_q <= (ev_q & ~clr_i) | evt_set;
      if (mask_wr_i) mask_q <= mask_wdata_i;
    end
  end

  assign evt_o  = ev_q;
  assign mask_o = mask_q;
  assign irq_o  = |(ev_q & mask_q);

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ev_q & ~clr_i) & ~ev_q) == '0);
  assert_edge_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(evt_set) & ~ev_q) == '0);
  assert_irq_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(mask_wr_i) || ($past(evt_set) != '0)));
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
  import gpio_evt_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter int ADDR_W     = 8,
  parameter bit SENSE_WIDE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic              irq_o
);
  logic [NPINS-1:0] sns_a, sns_b, rise_en, fall_en, edges, evt, mask, clr;
  logic             mask_wr;

  assign clr     = (wr_en_i && addr_i == ADDR_W'(OFS_EVT)) ? wdata_i : '0;
  assign mask_wr = wr_en_i && addr_i == ADDR_W'(OFS_MASK);

  gpio_sense_cfg #(.NPINS(NPINS), .ADDR_W(ADDR_W), .SENSE_WIDE(SENSE_WIDE)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .sns_a_o(sns_a), .sns_b_o(sns_b), .rise_en_o(rise_en), .fall_en_o(fall_en)
  );

  gpio_edge_det #(.NPINS(NPINS)) u_det (
    .clk_i, .rst_ni, .pin_i, .rise_en_i(rise_en), .fall_en_i(fall_en), .edge_o(edges)
  );

  gpio_evt_bank #(.NPINS(NPINS)) u_bank (
    .clk_i, .rst_ni, .edge_i(edges), .clr_i(clr), .mask_wr_i(mask_wr),
    .mask_wdata_i(wdata_i), .evt_o(evt), .mask_o(mask), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if      (addr_i == ADDR_W'(OFS_EVT))   rdata_o = evt;
    else if (addr_i == ADDR_W'(OFS_MASK))  rdata_o = mask;
    else if (addr_i == ADDR_W'(OFS_SNS_A)) rdata_o = sns_a;
    else if (addr_i == ADDR_W'(OFS_SNS_B)) rdata_o = sns_b;
  end

  assert_mask_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);
endmodule

// File: tb/gpio_evt_irq_bench.sv
`timescale 1ns/1ps
module gpio_evt_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_c, rdata_w;
  logic        irq_c, irq_w;
  int          n_tests = 0;
  int          n_fail = 0;
  logic [31:0] rc, rw;

  always #2.5 clk = ~clk;

  gpio_evt_irq #(.SENSE_WIDE(1'b0)) u_gpio_evt_irq (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_c), .irq_o(irq_c));

  gpio_evt_irq #(.SENSE_WIDE(1'b1)) u_gpio_evt_irq_w (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_w), .irq_o(irq_w));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); addr = a; #1; rc = rdata_c; rw = rdata_w;
  endtask

  task automatic drive(input int n, input logic v);
    @(negedge clk); pins[n] = v;
  endtask

  // expected detection from the sense encoding
  function automatic logic det(input bit wide, input logic [31:0] sa, input logic [31:0] sb,
                               input int n, input bit rising);
    logic [1:0] code;
    if (!wide) return rising ? !sa[31-n] : 1'b1;
    code = (n < 16) ? sa[(15 - n % 16)*2 +: 2] : sb[(15 - n % 16)*2 +: 2];
    if (code == 2'b10) return !rising;
    if (code == 2'b01) return rising;
    return 1'b1;
  endfunction

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pa [6];
    logic [31:0] pb [6];
    logic [31:0] bitm;
    pa[0] = 32'h0000_0000; pb[0] = 32'h0000_0000;
    pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0000;
    pa[2] = 32'h5555_5555; pb[2] = 32'h5555_5555;
    pa[3] = 32'hAAAA_AAAA; pb[3] = 32'hAAAA_AAAA;
    pa[4] = 32'hFFFF_FFFF; pb[4] = 32'hFFFF_FFFF;
    pa[5] = 32'h1B1B_1B1B; pb[5] = 32'hE4E4_E4E4;

    // R10: pins differ from reset state while reset is released
    pins = 32'h5A5A_C3C3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(8'h0C); chk("R1 evt c", rc, 0); chk("R1 evt w", rw, 0);
    chk("R10 no event after reset c", rc, 0); chk("R10 no event after reset w", rw, 0);
    rd(8'h10); chk("R1 mask c", rc, 0); chk("R1 mask w", rw, 0);
    rd(8'h14); chk("R1 sns a c", rc, 0); chk("R1 sns a w", rw, 0);
    rd(8'h18); chk("R1 sns b c", rc, 0); chk("R1 sns b w", rw, 0);
    chk("R1 irq c", {31'd0, irq_c}, 0); chk("R1 irq w", {31'd0, irq_w}, 0);
    pins = '0;
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C); chk("R3 clear all c", rc, 0); chk("R3 clear all w", rw, 0);

    // R2 R7 R8 R9: sweep every pin under each sense pattern
    for (int p = 0; p < 6; p++) begin
      wr(8'h14, pa[p]); wr(8'h18, pb[p]);
      rd(8'h14); chk("R2 sns a c", rc, pa[p]); chk("R8 sns a w", rw, pa[p]);
      rd(8'h18); chk("R9 sns b ignored c", rc, 0); chk("R8 sns b w", rw, pb[p]);
      for (int n = 0; n < 32; n++) begin
        bitm = 32'h1 << (31 - n);
        wr(8'h0C, 32'hFFFF_FFFF);
        drive(n, 1'b1);
        rd(8'h0C);
        chk("R7 rise c", rc, det(1'b0, pa[p], pb[p], n, 1'b1) ? bitm : 32'h0);
        chk("R8 rise w", rw, det(1'b1, pa[p], pb[p], n, 1'b1) ? bitm : 32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        drive(n, 1'b0);
        rd(8'h0C);
        chk("R7 fall c", rc, det(1'b0, pa[p], pb[p], n, 1'b0) ? bitm : 32'h0);
        chk("R8 fall w", rw, det(1'b1, pa[p], pb[p], n, 1'b0) ? bitm : 32'h0);
        chk("R6 masked irq c", {31'd0, irq_c}, 0);
      end
    end
    wr(8'h14, 32'h0); wr(8'h18, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R3 partial clears; pins 0..7 rise -> bits 31..24
    @(negedge clk); pins[7:0] = 8'hFF;
    rd(8'h0C); chk("R2 pins 0-7 c", rc, 32'hFF00_0000); chk("R2 pins 0-7 w", rw, 32'hFF00_0000);
    wr(8'h0C, 32'h0F00_0000);
    rd(8'h0C); chk("R3 partial c", rc, 32'hF000_0000); chk("R3 partial w", rw, 32'hF000_0000);
    wr(8'h0C, 32'h0);
    rd(8'h0C); chk("R3 zero write c", rc, 32'hF000_0000);

    // R5 R6 irq gating
    chk("R6 latched no irq", {31'd0, irq_c}, 0);
    wr(8'h10, 32'h0F00_0000);
    rd(8'h10); chk("R2 mask readback", rc, 32'h0F00_0000);
    chk("R5 non-overlap irq", {31'd0, irq_c}, 0);
    wr(8'h10, 32'h1000_0000);
    #1 chk("R5 overlap irq c", {31'd0, irq_c}, 1); chk("R5 overlap irq w", {31'd0, irq_w}, 1);
    wr(8'h0C, 32'h1000_0000);
    #1 chk("R5 cleared irq", {31'd0, irq_c}, 0);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0);
    @(negedge clk); pins[7:0] = 8'h00;
    wr(8'h0C, 32'hFFFF_FFFF);

    // R11 latency: pin 3 -> bit 28
    rd(8'h0C);
    pins[3] = 1'b1;
    #1 chk("R11 before edge", rdata_c, 0);
    @(negedge clk); chk("R11 after edge", rdata_c, 32'h1000_0000);
    wr(8'h10, 32'h1000_0000);
    #1 chk("R11 irq", {31'd0, irq_c}, 1);
    wr(8'h10, 32'h0);
    pins[3] = 1'b0;
    wr(8'h0C, 32'hFFFF_FFFF);

    // R4 collision: pin 5 -> bit 26
    drive(5, 1'b1);
    rd(8'h0C); chk("R4 setup", rc, 32'h0400_0000);
    @(negedge clk); pins[5] = 1'b0; wr_en = 1'b1; addr = 8'h0C; wdata = 32'h0400_0000;
    @(negedge clk); wr_en = 1'b0;
    rd(8'h0C); chk("R4 edge beats clear c", rc, 32'h0400_0000); chk("R4 edge beats clear w", rw, 32'h0400_0000);
    wr(8'h0C, 32'h0400_0000);
    rd(8'h0C); chk("R4 plain clear", rc, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule